// File: doc/BRIEF.md
# Low-Voltage Detect Register Block

This block gives software a view of a supply-voltage monitor. Two digital flags from an analog comparator arrive asynchronously: one says the supply has fallen below the assert level, the other says it has risen above the release level. After a two-stage synchronizer they drive a hysteretic status bit. The bit can only be high while the chip is in full-power mode. Any change of that status, up or down, latches a sticky change flag. Software clears the flag by writing 1 to it. When the interrupt enable is also set, the flag raises an interrupt request.

Access is through a byte-wide bus with a write strobe, an address and combinational read data. Two locations exist. Offset 0 is a reserved test location. Offset 1 is the control/status byte. A read always shows the register contents as they stand before any write in the same cycle. A write takes effect at the clock edge that ends that cycle.

Top module: `lvd_regif`

## Requirements
- R1: After synchronous reset, both offsets read 0x00 and the interrupt request is low.
- R2: Offset 0 always reads 0x00, and a write to it changes neither offset's contents.
- R3: At offset 1, bit 0 is the change flag, bit 1 is the interrupt enable (read/write) and bit 2 is the status. Bits 7 to 3 read 0 whatever was written.
- R4: In full-power mode the status goes to 1 when the synchronized below-level input is 1. Otherwise it goes to 0 when the synchronized above-level input is 1, and it holds when neither is 1. Below-level wins when both are 1. An input change reaches the status at the third rising edge after it is applied.
- R5: Power mode 2'b00 is full power. Mode 2'b01 (reduced power), 2'b10 (shutdown) or 2'b11 forces the status to 0 at the next rising edge.
- R6: Writes to the status bit have no effect.
- R7: The change flag goes to 1 at the same edge where the status changes value, in either direction.
- R8: Writing 1 to bit 0 of offset 1 clears the change flag. Writing 0 there leaves it unchanged, and without a change or a clear the flag holds.
- R9: When a status change and a clearing write fall on the same edge, the flag ends up 1.
- R10: The interrupt request is high exactly while both the change flag and the interrupt enable are 1.
- R11: Entering reduced-power mode does not clear the change flag.
- R12: Read data in a write cycle shows the pre-write contents, and the written value appears from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_below_i | input | 1 | Asynchronous comparator flag: supply below assert level |
| cmp_above_i | input | 1 | Asynchronous comparator flag: supply above release level |
| pwr_mode_i | input | 2 | Power mode: 00 full, 01 reduced, 10 shutdown |
| wr_en_i | input | 1 | Write strobe for the current cycle |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
A status change and a write-1-to-clear of the change flag can land on the same clock edge. The bench provokes this by changing a comparator input and then counting the synchronizer stages. It places the clearing write exactly on the third rising edge after the input change, which is the edge where the status flips. It judges the result by reading a set flag right after that edge, and then by issuing the same clear alone to show that the clear path works.

// File: rtl/lvd_regif_pkg.sv
package lvd_regif_pkg;

    localparam int CTRL_OFS    = 1;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        PM_FULL     = 2'b00,
        PM_REDUCED  = 2'b01,
        PM_SHUTDOWN = 2'b10,
        PM_RSVD     = 2'b11
    } pwr_mode_e;

    // Byte layout of the control/status location
    typedef struct packed {
        logic [4:0] rsvd;
        logic       status;
        logic       irq_en;
        logic       chg_flag;
    } ctrl_reg_t;

    typedef struct packed {
        logic below;
        logic above;
    } cmp_pair_t;

    // Hysteretic next-status: below wins, above releases, otherwise hold
    function automatic logic next_status(logic full, cmp_pair_t cmp, logic cur);
        if (!full)          return 1'b0;
        else if (cmp.below) return 1'b1;
        else if (cmp.above) return 1'b0;
        else                return cur;
    endfunction

    function automatic ctrl_reg_t pack_ctrl(logic st, logic en, logic fl);
        ctrl_reg_t r;
        r          = '0;
        r.status   = st;
        r.irq_en   = en;
        r.chg_flag = fl;
        return r;
    endfunction

endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/lvd_status.sv
module lvd_status
    import lvd_regif_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cmp_pair_t cmp_i,
    input  logic      full_pwr_i,
    output logic      status_o,
    output logic      change_o
);

    logic status_q, status_d;

    always_comb begin
        status_d = next_status(full_pwr_i, cmp_i, status_q);
        change_o = (status_d != status_q);
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= 1'b0;
        else     status_q <= status_d;
    end

    assign status_o = status_q;

    // R5
    pwr_forced_low_chk: assert property (@(posedge clk) disable iff (rst)
        !full_pwr_i |=> !status_o);

    // R4
    below_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (full_pwr_i && cmp_i.below) |=> status_o);

    // R4
    between_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full_pwr_i && !cmp_i.below && !cmp_i.above) |=> $stable(status_o));

endmodule

// File: rtl/lvd_csr.sv
module lvd_csr
    import lvd_regif_pkg::*;
#(
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              status_i,
    input  logic              change_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFS);

    ctrl_reg_t wr_fields;
    logic      hit_ctrl, ctrl_wr, clr_req;
    logic      en_q, flag_q, flag_d;
    logic      unused_wbits;

    always_comb begin
        wr_fields = ctrl_reg_t'(wdata_i);
        hit_ctrl  = (addr_i == CTRL_ADDR);
        ctrl_wr   = wr_en_i && hit_ctrl;
        clr_req   = ctrl_wr && wr_fields.chg_flag;
        // set has priority over clear
        if (change_i)     flag_d = 1'b1;
        else if (clr_req) flag_d = 1'b0;
        else              flag_d = flag_q;
    end

    assign unused_wbits = ^{wr_fields.rsvd, wr_fields.status};

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
            if (ctrl_wr) en_q <= wr_fields.irq_en;
        end
    end

    assign rdata_o = hit_ctrl ? pack_ctrl(status_i, en_q, flag_q) : 8'h00;
    assign irq_o   = flag_q && en_q;

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        change_i |=> flag_q);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && hit_ctrl && wdata_i[0] && !change_i) |=> !flag_q);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !change_i && !(wr_en_i && hit_ctrl && wdata_i[0])) |=> flag_q);

    // R2
    test_reg_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !hit_ctrl && !change_i) |=> ($stable(en_q) && $stable(flag_q)));

endmodule

// File: rtl/lvd_regif.sv
module lvd_regif
    import lvd_regif_pkg::*;
#(
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_below_i,
    input  logic              cmp_above_i,
    input  logic [1:0]        pwr_mode_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o
);

    localparam int CMP_W = $bits(cmp_pair_t);

    cmp_pair_t cmp_raw, cmp_sync;
    logic      full_pwr, status, change;

    assign cmp_raw.below = cmp_below_i;
    assign cmp_raw.above = cmp_above_i;
    assign full_pwr      = (pwr_mode_e'(pwr_mode_i) == PM_FULL);

    lvd_sync #(
        .WIDTH  (CMP_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (cmp_raw),
        .q_o (cmp_sync)
    );

    lvd_status u_status (
        .clk        (clk),
        .rst        (rst),
        .cmp_i      (cmp_sync),
        .full_pwr_i (full_pwr),
        .status_o   (status),
        .change_o   (change)
    );

    lvd_csr #(
        .ADDR_W (ADDR_W)
    ) u_csr (
        .clk      (clk),
        .rst      (rst),
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .status_i (status),
        .change_i (change),
        .rdata_o  (rdata_o),
        .irq_o    (irq_o)
    );

endmodule

// File: tb/lvd_regif_tb_top.sv
`timescale 1ns/1ps
module lvd_regif_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_below = 1'b0, cmp_above = 1'b0;
    logic [1:0] pwr_mode = 2'b00;
    logic       wr_en = 1'b0;
    logic [0:0] addr = 1'b1;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;
    int         vectors = 0, miscompares = 0;

    always #2.5 clk = ~clk;

    lvd_regif #(.ADDR_W(1)) dut_i (
        .clk(clk), .rst(rst), .cmp_below_i(cmp_below), .cmp_above_i(cmp_above),
        .pwr_mode_i(pwr_mode), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 1'b1;
    endtask

    task automatic set_cmp(input logic b, input logic a);
        cmp_below = b; cmp_above = a;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(1'b0, d); chk("R1 test offset after reset", d, 8'h00);
        rd(1'b1, d); chk("R1 ctrl offset after reset", d, 8'h00);
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_test_reg();
        logic [7:0] d;
        wr(1'b0, 8'hFF);
        rd(1'b0, d); chk("R2 test offset reads zero", d, 8'h00);
        rd(1'b1, d); chk("R2 write to test offset leaves ctrl", d, 8'h00);
    endtask

    task automatic t_layout();
        logic [7:0] d;
        wr(1'b1, 8'hFC);
        rd(1'b1, d); chk("R3/R6 high bits and status not writable", d, 8'h00);
        wr(1'b1, 8'h02);
        rd(1'b1, d); chk("R3 enable bit read back", d, 8'h02);
        chk("R10 no irq without flag", {7'b0, irq}, 8'h00);
        wr(1'b1, 8'h00);
        rd(1'b1, d); chk("R3 enable cleared", d, 8'h00);
    endtask

    task automatic t_rise();
        logic [7:0] d;
        cmp_below = 1'b1; cmp_above = 1'b0;
        repeat (2) @(negedge clk);
        rd(1'b1, d); chk("R4 status not yet through synchronizer", d, 8'h00);
        @(negedge clk);
        rd(1'b1, d); chk("R4/R7 status rises on third edge with flag", d, 8'h05);
        chk("R10 no irq while disabled", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_hold_w1c();
        logic [7:0] d;
        cmp_below = 1'b0; cmp_above = 1'b0;
        repeat (5) @(negedge clk);
        rd(1'b1, d); chk("R4 status holds between levels", d, 8'h05);
        wr(1'b1, 8'h00);
        rd(1'b1, d); chk("R8 writing 0 keeps flag", d, 8'h05);
        wr(1'b1, 8'h01);
        rd(1'b1, d); chk("R8 writing 1 clears flag", d, 8'h04);
    endtask

    task automatic t_fall_irq();
        logic [7:0] d;
        wr(1'b1, 8'h02);
        rd(1'b1, d); chk("R3 enable set", d, 8'h06);
        set_cmp(1'b0, 1'b1);
        rd(1'b1, d); chk("R7 falling status sets flag", d, 8'h03);
        chk("R10 irq with flag and enable", {7'b0, irq}, 8'h01);
        @(negedge clk);
        wr_en = 1'b1; addr = 1'b1; wdata = 8'h02;
        #1 chk("R12 read shows pre-write value", rdata, 8'h03);
        @(negedge clk);
        wr_en = 1'b0;
        rd(1'b1, d); chk("R12 enable unchanged, flag kept", d, 8'h03);
        wr(1'b1, 8'h03);
        rd(1'b1, d); chk("R8 clear keeps enable", d, 8'h02);
        chk("R10 irq drops with flag", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_both();
        logic [7:0] d;
        set_cmp(1'b1, 1'b1);
        rd(1'b1, d); chk("R4 below wins when both asserted", d, 8'h07);
        wr(1'b1, 8'h03);
        rd(1'b1, d); chk("R8 clear after both", d, 8'h06);
    endtask

    task automatic t_modes();
        logic [7:0] d;
        pwr_mode = 2'b01;
        @(negedge clk);
        rd(1'b1, d); chk("R5 reduced mode forces status low next edge", d, 8'h03);
        repeat (3) @(negedge clk);
        rd(1'b1, d); chk("R5 status stays low in reduced mode", d, 8'h03);
        wr(1'b1, 8'h03);
        pwr_mode = 2'b00;
        @(negedge clk);
        rd(1'b1, d); chk("R4/R7 full power restores status", d, 8'h07);
        wr(1'b1, 8'h03);
        pwr_mode = 2'b10;
        @(negedge clk);
        rd(1'b1, d); chk("R5 shutdown forces status low", d, 8'h03);
        pwr_mode = 2'b00;
        @(negedge clk);
        wr(1'b1, 8'h03);
        rd(1'b1, d); chk("R8 clear after shutdown round trip", d, 8'h06);
    endtask

    task automatic t_retain();
        logic [7:0] d;
        set_cmp(1'b0, 1'b1);
        rd(1'b1, d); chk("R7 fall before mode entry", d, 8'h03);
        pwr_mode = 2'b01;
        repeat (3) @(negedge clk);
        rd(1'b1, d); chk("R11 flag survives reduced-power entry", d, 8'h03);
        chk("R11 irq still asserted", {7'b0, irq}, 8'h01);
        pwr_mode = 2'b00;
        repeat (2) @(negedge clk);
        wr(1'b1, 8'h03);
        rd(1'b1, d); chk("R8 clear after retain", d, 8'h02);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        cmp_below = 1'b1; cmp_above = 1'b0;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; addr = 1'b1; wdata = 8'h03;
        @(negedge clk);
        wr_en = 1'b0;
        rd(1'b1, d); chk("R9 set wins over same-edge clear", d, 8'h07);
        wr(1'b1, 8'h03);
        rd(1'b1, d); chk("R9 lone clear still works", d, 8'h06);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_test_reg();
        t_layout();
        t_rise();
        t_hold_w1c();
        t_fall_irq();
        t_both();
        t_modes();
        t_retain();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule